// File: doc/BRIEF.md
# Boot Block Lock Manager

This block holds the write-protection state of every erase block in a flash array whose map mixes small and large blocks. Eight small parameter blocks sit at one end of the word address space, and a parameterised number of large main blocks fill the rest. The parameter blocks are at the low end for a bottom-boot build and at the high end for a top-boot build. Each block carries two state bits. The locked bit is set by lock and lock-down commands and is cleared by unlock. The locked-down bit is a sticky bit that only reset clears.

The surrounding command decoder passes every bus write to the block. A write of 60h arms the block. The next write supplies the confirm byte: 01h locks, D0h unlocks and 2Fh locks down the block that holds the write address. Any other confirm byte is a sequence error.

While the host is in configuration-read mode, a read at word offset 2 of any block returns that block's status byte. A separate query port gives the program and erase engine a locked flag for any address.

Top module: `boot_lock_mgr`

## Requirements
- R1: After a synchronous reset every block reads locked (status bit 0 = 1) and not locked down (status bit 1 = 0), and `seq_err` and `addr_err` are 0. Reset is the only action that clears a lock-down.
- R2: A write of 60h followed by a write of 01h sets the locked bit of the block that holds the second write's address.
- R3: A write of 60h followed by a write of D0h clears the locked bit of the addressed block when that block is not locked down.
- R4: A write of 60h followed by a write of 2Fh sets both the locked bit and the locked-down bit of the addressed block.
- R5: An unlock of a locked-down block has no effect while `wp_n` is 0. While `wp_n` is 1 the unlock clears the locked bit, and the locked-down bit stays set.
- R6: After 60h, a confirm byte other than 01h, D0h or 2Fh raises `seq_err` for exactly the cycle after that write. No lock state changes, and the block returns to the unarmed state.
- R7: A valid confirm byte whose address is at or above the end of the array raises `addr_err` for the cycle after that write and changes no lock state.
- R8: While `cfg_rd_en` is 1 and `cfg_rd_addr` is word offset 2 of a block, `cfg_rd_valid` is 1 and `cfg_rd_data` is {6'b0, locked-down, locked}. In every other case both are 0. The result is combinational from the address and the current state.
- R9: Blocks are indexed in ascending address order. Bottom-boot: index 0-7 are 4096-word blocks from word 0, and main blocks of 32768 words start at word 8000h. Top-boot: main blocks start at word 0, and the eight 4096-word blocks follow them.
- R10: `pe_locked` is combinationally the locked bit of the block that holds `pe_addr`. It is 1 for an address beyond the array.
- R11: A write that is not part of a 60h-armed pair has no effect on lock state. A lock change shows on the query outputs in the cycle after its confirm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect; low keeps locked-down blocks locked |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| cfg_rd_en | input | 1 | Host is in configuration-read mode |
| cfg_rd_addr | input | ADDR_W | Word address of the configuration read |
| cfg_rd_valid | output | 1 | Read address is a block's status word |
| cfg_rd_data | output | 8 | Block status byte |
| pe_addr | input | ADDR_W | Address queried by the program/erase engine |
| pe_locked | output | 1 | Queried block is locked or address is invalid |
| seq_err | output | 1 | One-cycle pulse: bad confirm byte |
| addr_err | output | 1 | One-cycle pulse: confirm aimed past the array |

## Verification
Some properties are checked by assertions on every cycle:
- a locked-down bit never falls outside reset;
- a locked, locked-down block stays locked while `wp_n` is low;
- the two error pulses never coincide;
- an armed write always disarms;
- the reserved status bits stay zero;
- the mapped index stays inside the block range.

Other behaviour depends on the address map and on the order of commands, and only the bench can show it. This covers boundary addresses in both boot layouts, the exact status value after each command, and the effect of a reset on lock-down. It also covers an unarmed confirm byte, which must be ignored. The bench runs a bottom-boot and a top-boot instance side by side against a behavioural model that walks the block list.

// File: rtl/blk_lock_pkg.sv
// Package: command bytes and update opcodes shared by the lock manager.
// Assumes 8-bit command bytes on the low data lane.
package blk_lock_pkg;
    localparam logic [7:0] CMD_SETUP  = 8'h60;
    localparam logic [7:0] CMD_LOCK   = 8'h01;
    localparam logic [7:0] CMD_UNLOCK = 8'hD0;
    localparam logic [7:0] CMD_LDOWN  = 8'h2F;

    typedef enum logic [1:0] {
        OP_LOCK   = 2'd0,
        OP_UNLOCK = 2'd1,
        OP_LDOWN  = 2'd2
    } lk_op_e;
endpackage

// File: rtl/blk_addr_map.sv
// Module: blk_addr_map
// Maps a word address to a block index for a bottom- or top-boot layout.
// It also flags whether the address is word offset 2 of its block and
// whether it falls inside the array.
// Assumes block sizes are powers of two and each region is aligned to its own block size.
module blk_addr_map #(
    parameter int ADDR_W      = 20,
    parameter int NUM_PARAM   = 8,
    parameter int NUM_MAIN    = 15,
    parameter int PARAM_SHIFT = 12,
    parameter int MAIN_SHIFT  = 15,
    parameter bit TOP_BOOT    = 1'b0,
    parameter int IDX_W       = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              at_status,
    output logic              in_range
);
    localparam int AW1 = ADDR_W + 1;
    localparam logic [AW1-1:0] P_SPAN = AW1'(NUM_PARAM << PARAM_SHIFT);
    localparam logic [AW1-1:0] M_SPAN = AW1'(NUM_MAIN << MAIN_SHIFT);
    localparam logic [AW1-1:0] P_MASK = AW1'((1 << PARAM_SHIFT) - 1);
    localparam logic [AW1-1:0] M_MASK = AW1'((1 << MAIN_SHIFT) - 1);

    logic [AW1-1:0] a_ext;
    logic [AW1-1:0] rel;
    logic           small_blk;

    assign a_ext = {1'b0, addr};

    generate
        if (TOP_BOOT == 1'b0) begin : g_bottom
            // Purpose: small blocks from word 0, main blocks after them.
            always_comb begin
                if (a_ext < P_SPAN) begin
                    rel       = a_ext;
                    small_blk = 1'b1;
                    idx       = IDX_W'(a_ext >> PARAM_SHIFT);
                end else begin
                    rel       = a_ext - P_SPAN;
                    small_blk = 1'b0;
                    idx       = IDX_W'(NUM_PARAM) + IDX_W'(rel >> MAIN_SHIFT);
                end
            end
        end else begin : g_top
            // Purpose: main blocks from word 0, small blocks after them.
            always_comb begin
                if (a_ext < M_SPAN) begin
                    rel       = a_ext;
                    small_blk = 1'b0;
                    idx       = IDX_W'(a_ext >> MAIN_SHIFT);
                end else begin
                    rel       = a_ext - M_SPAN;
                    small_blk = 1'b1;
                    idx       = IDX_W'(NUM_MAIN) + IDX_W'(rel >> PARAM_SHIFT);
                end
            end
        end
    endgenerate

    // Purpose: offset-2 detection within the block and range check.
    always_comb begin
        at_status = ((rel & (small_blk ? P_MASK : M_MASK)) == AW1'(2));
        in_range  = (a_ext < (P_SPAN + M_SPAN));
    end
endmodule

// File: rtl/lock_cmd_fsm.sv
// Module: lock_cmd_fsm
// Two-write decoder: a setup byte arms it, and the next write confirms or errs.
// Assumes wr_en is high for one cycle per bus write.
module lock_cmd_fsm
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       addr_ok,
    output logic       upd_en,
    output lk_op_e     upd_op,
    output logic       seq_err,
    output logic       addr_err
);
    logic armed_q;
    logic bad_byte;
    logic bad_addr;
    logic known;

    // Purpose: classify the confirm byte while armed.
    always_comb begin
        known  = 1'b0;
        upd_op = OP_LOCK;
        if (wr_data == CMD_LOCK) begin
            known = 1'b1;
            upd_op = OP_LOCK;
        end else if (wr_data == CMD_UNLOCK) begin
            known = 1'b1;
            upd_op = OP_UNLOCK;
        end else if (wr_data == CMD_LDOWN) begin
            known = 1'b1;
            upd_op = OP_LDOWN;
        end
        bad_byte = wr_en && armed_q && !known;
        bad_addr = wr_en && armed_q && known && !addr_ok;
        upd_en   = wr_en && armed_q && known && addr_ok;
    end

    // Purpose: arm state and registered error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            seq_err  <= 1'b0;
            addr_err <= 1'b0;
        end else begin
            seq_err  <= bad_byte;
            addr_err <= bad_addr;
            if (wr_en) begin
                armed_q <= !armed_q && (wr_data == CMD_SETUP);
            end
        end
    end

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_err && addr_err)); // R6
    AST_CONFIRM_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed_q) |=> !armed_q); // R6
endmodule

// File: rtl/lock_state_array.sv
// Module: lock_state_array
// Holds the locked and locked-down bits of every block and serves two read ports.
// Assumes at most one update per cycle. An index beyond the last block reads as zero.
module lock_state_array
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLK = 23,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  lk_op_e           upd_op,
    input  logic [IDX_W-1:0] qa_idx,
    output logic             qa_locked,
    output logic             qa_ldown,
    input  logic [IDX_W-1:0] qb_idx,
    output logic             qb_locked
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BLK - 1);

    logic [NUM_BLK-1:0] locked_q;
    logic [NUM_BLK-1:0] ldown_q;

    generate
        for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
            // Purpose: per-block lock and sticky lock-down state.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    locked_q[b] <= 1'b1;
                    ldown_q[b]  <= 1'b0;
                end else if (upd_en && (upd_idx == IDX_W'(b))) begin
                    case (upd_op)
                        OP_LOCK:   locked_q[b] <= 1'b1;
                        OP_LDOWN: begin
                            locked_q[b] <= 1'b1;
                            ldown_q[b]  <= 1'b1;
                        end
                        default: begin
                            if (!(ldown_q[b] && !wp_n)) begin
                                locked_q[b] <= 1'b0;
                            end
                        end
                    endcase
                end
            end

            AST_LDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                ldown_q[b] |=> ldown_q[b]); // R5
            AST_WP_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
                (ldown_q[b] && locked_q[b] && !wp_n) |=> locked_q[b]); // R5
        end
    endgenerate

    // Purpose: guarded read ports.
    always_comb begin
        qa_locked = (qa_idx <= LAST) ? locked_q[qa_idx] : 1'b0;
        qa_ldown  = (qa_idx <= LAST) ? ldown_q[qa_idx]  : 1'b0;
        qb_locked = (qb_idx <= LAST) ? locked_q[qb_idx] : 1'b0;
    end
endmodule

// File: rtl/boot_lock_mgr.sv
// Module: boot_lock_mgr (top)
// Per-block lock manager for a boot-block flash map. It decodes lock commands,
// answers status reads at block offset 2 and gives a locked flag to the program/erase engine.
// Assumes the outer command decoder asserts cfg_rd_en during configuration-read mode.
module boot_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int NUM_PARAM   = 8,
    parameter int NUM_MAIN    = 15,
    parameter int PARAM_SHIFT = 12,
    parameter int MAIN_SHIFT  = 15,
    parameter bit TOP_BOOT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cfg_rd_en,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic              cfg_rd_valid,
    output logic [7:0]        cfg_rd_data,
    input  logic [ADDR_W-1:0] pe_addr,
    output logic              pe_locked,
    output logic              seq_err,
    output logic              addr_err
);
    localparam int NUM_BLK = NUM_PARAM + NUM_MAIN;
    localparam int IDX_W   = $clog2(NUM_BLK);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BLK - 1);

    logic [IDX_W-1:0] wr_idx, rd_idx, pe_idx;
    logic wr_stat, wr_ok, rd_stat, rd_ok, pe_stat, pe_ok;
    logic upd_en, rd_locked, rd_ldown, pe_blk_locked;
    lk_op_e upd_op;

    blk_addr_map #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN),
        .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT), .TOP_BOOT(TOP_BOOT),
        .IDX_W(IDX_W)) u_map_wr (
        .addr(wr_addr), .idx(wr_idx), .at_status(wr_stat), .in_range(wr_ok));

    blk_addr_map #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN),
        .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT), .TOP_BOOT(TOP_BOOT),
        .IDX_W(IDX_W)) u_map_rd (
        .addr(cfg_rd_addr), .idx(rd_idx), .at_status(rd_stat), .in_range(rd_ok));

    blk_addr_map #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .NUM_MAIN(NUM_MAIN),
        .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT), .TOP_BOOT(TOP_BOOT),
        .IDX_W(IDX_W)) u_map_pe (
        .addr(pe_addr), .idx(pe_idx), .at_status(pe_stat), .in_range(pe_ok));

    lock_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .addr_ok(wr_ok), .upd_en(upd_en), .upd_op(upd_op),
        .seq_err(seq_err), .addr_err(addr_err));

    lock_state_array #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_state (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .upd_en(upd_en), .upd_idx(wr_idx), .upd_op(upd_op),
        .qa_idx(rd_idx), .qa_locked(rd_locked), .qa_ldown(rd_ldown),
        .qb_idx(pe_idx), .qb_locked(pe_blk_locked));

    // Purpose: status byte for configuration reads and engine lock flag.
    always_comb begin
        cfg_rd_valid = cfg_rd_en && rd_ok && rd_stat;
        cfg_rd_data  = cfg_rd_valid ? {6'b0, rd_ldown, rd_locked} : 8'h00;
        pe_locked    = !pe_ok || pe_blk_locked;
    end

    AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[7:2] == 6'b0); // R8
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (rd_idx <= LAST)); // R9
    AST_WR_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> (wr_idx <= LAST)); // R9
endmodule

// File: tb/boot_lock_mgr_tb_top.sv
// Bench: a bottom-boot and a top-boot instance share one stimulus. A behavioural
// model that walks the block list predicts every output, and the bench compares each cycle.
module boot_lock_mgr_tb_top;
    localparam int AW = 20, NP = 8, NM = 15, NB = 23, PSH = 12, MSH = 15;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0, wp_n = 1'b0, wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, cfg_rd_addr = '0, pe_addr = '0;
    logic [7:0]    wr_data = 8'h00;

    logic       v_b, v_t, pl_b, pl_t, se_b, se_t, ae_b, ae_t;
    logic [7:0] d_b, d_t;

    boot_lock_mgr #(.ADDR_W(AW), .TOP_BOOT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_valid(v_b), .cfg_rd_data(d_b), .pe_addr(pe_addr), .pe_locked(pl_b),
        .seq_err(se_b), .addr_err(ae_b));

    boot_lock_mgr #(.ADDR_W(AW), .TOP_BOOT(1'b1)) dut_t_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_valid(v_t), .cfg_rd_data(d_t), .pe_addr(pe_addr), .pe_locked(pl_t),
        .seq_err(se_t), .addr_err(ae_t));

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    int lk[2][NB];
    int ld[2][NB];
    bit armed = 1'b0;
    int e_seq = 0, e_addr = 0;

    // Walks the block list; returns block index or -1.
    function automatic int map_blk(int a, int top, output int off);
        int base = 0;
        int sz;
        off = 0;
        for (int b = 0; b < NB; b++) begin
            if (top != 0) sz = (b < NM) ? (1 << MSH) : (1 << PSH);
            else          sz = (b < NP) ? (1 << PSH) : (1 << MSH);
            if (a >= base && a < base + sz) begin
                off = a - base;
                return b;
            end
            base += sz;
        end
        return -1;
    endfunction

    function automatic int blk_base(int blk, int top);
        int base = 0;
        for (int b = 0; b < blk; b++) begin
            if (top != 0) base += (b < NM) ? (1 << MSH) : (1 << PSH);
            else          base += (b < NP) ? (1 << PSH) : (1 << MSH);
        end
        return base;
    endfunction

    // Reference model update at each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < 2; m++)
                for (int b = 0; b < NB; b++) begin
                    lk[m][b] = 1;
                    ld[m][b] = 0;
                end
            armed = 1'b0; e_seq = 0; e_addr = 0;
        end else begin
            e_seq = 0; e_addr = 0;
            if (wr_en) begin
                if (!armed) begin
                    armed = (wr_data == 8'h60);
                end else begin
                    armed = 1'b0;
                    if (wr_data != 8'h01 && wr_data != 8'hD0 && wr_data != 8'h2F) begin
                        e_seq = 1;
                    end else begin
                        for (int m = 0; m < 2; m++) begin
                            int off;
                            int ix;
                            ix = map_blk(int'(wr_addr), m, off);
                            if (ix < 0) e_addr = 1;
                            else if (wr_data == 8'h01) lk[m][ix] = 1;
                            else if (wr_data == 8'h2F) begin
                                lk[m][ix] = 1; ld[m][ix] = 1;
                            end else if (!(ld[m][ix] == 1 && !wp_n)) lk[m][ix] = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic cmp_one(int m, logic v, logic [7:0] d, logic pl, logic se, logic ae);
        int off, ix, pix, ev, ed, ep;
        ix  = map_blk(int'(cfg_rd_addr), m, off);
        ev  = (cfg_rd_en && ix >= 0 && off == 2) ? 1 : 0;
        ed  = ev ? (ld[m][ix] * 2 + lk[m][ix]) : 0;
        pix = map_blk(int'(pe_addr), m, off);
        ep  = (pix < 0) ? 1 : lk[m][pix];
        chk(m ? "top cfg_rd_valid" : "bot cfg_rd_valid", int'(v), ev);
        chk(m ? "top cfg_rd_data"  : "bot cfg_rd_data",  int'(d), ed);
        chk(m ? "top pe_locked"    : "bot pe_locked",    int'(pl), ep);
        chk(m ? "top seq_err"      : "bot seq_err",      int'(se), e_seq);
        chk(m ? "top addr_err"     : "bot addr_err",     int'(ae), e_addr);
    endtask

    // Compare away from the edge, after model and DUT have settled.
    always @(posedge clk) begin
        #5;
        cmp_one(0, v_b, d_b, pl_b, se_b, ae_b);
        cmp_one(1, v_t, d_t, pl_t, se_t, ae_t);
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lk_cmd(int a, int d);
        wr(a, 8'h60);
        wr(a, d);
    endtask

    task automatic look(int a);
        @(negedge clk);
        cfg_rd_addr = AW'(a); pe_addr = AW'(a); cfg_rd_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state for every block in both layouts
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) look(blk_base(b, 0) + 2);
        for (int b = 0; b < NB; b++) look(blk_base(b, 1) + 2);

        // R3 then R2 on a small block (bottom index 3)
        cur_req = "R3";
        lk_cmd(32'h3005, 8'hD0);
        look(32'h3002);
        cur_req = "R2";
        lk_cmd(32'h3FFF, 8'h01);
        look(32'h3002);

        // R11: an unarmed confirm byte has no effect
        cur_req = "R11";
        lk_cmd(32'h4002, 8'hD0);
        look(32'h4002);
        wr(32'h4002, 8'h01);
        look(32'h4002);
        wr(32'h4002, 8'h2F);
        look(32'h4002);

        // R4 lock-down of a main block
        cur_req = "R4";
        lk_cmd(32'h40007, 8'h2F);
        look(32'h40002);

        // R5: write-protect interaction with lock-down
        cur_req = "R5";
        wp_n = 1'b0;
        lk_cmd(32'h40002, 8'hD0);
        look(32'h40002);
        wp_n = 1'b1;
        lk_cmd(32'h40002, 8'hD0);
        look(32'h40002);
        lk_cmd(32'h40002, 8'h01);
        look(32'h40002);
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(32'h40002);

        // R6: bad confirm bytes
        cur_req = "R6";
        lk_cmd(32'h3002, 8'hD0);
        look(32'h3002);
        lk_cmd(32'h3002, 8'h55);
        look(32'h3002);
        lk_cmd(32'h5002, 8'h60);
        wr(32'h5002, 8'hD0);
        look(32'h5002);

        // R7: confirm aimed past the array
        cur_req = "R7";
        lk_cmd(32'h80002, 8'hD0);
        look(32'h80002);
        lk_cmd(32'hFFFFF, 8'h2F);
        look(32'h7F002);

        // R8: mode gating and offsets other than 2
        cur_req = "R8";
        @(negedge clk); cfg_rd_en = 1'b0; cfg_rd_addr = AW'(32'h3002);
        @(negedge clk);
        look(32'h3003);
        look(32'h3000);
        look(32'h48002);

        // R9: layout boundaries
        cur_req = "R9";
        look(32'h07FFF); look(32'h08000); look(32'h08002); look(32'h0F002);
        look(32'h78002); look(32'h79002); look(32'h7F002); look(32'h7FFFF);

        // R10: engine query, including beyond the array
        cur_req = "R10";
        lk_cmd(32'h79000, 8'hD0);
        look(32'h79123); look(32'h78FFF); look(32'h90000); look(32'hFFFFF);

        // R11: mixed traffic
        cur_req = "R11";
        for (int i = 0; i < 800; i++) begin
            int r, a, d;
            r = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) a = int'($urandom_range(0, 32'h9FFFF));
            else a = blk_base(int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 1)))
                     + int'($urandom_range(0, 4095));
            wp_n = 1'($urandom_range(0, 1));
            case (r)
                0, 1: lk_cmd(a, 8'h01);
                2, 3, 4: lk_cmd(a, 8'hD0);
                5: lk_cmd(a, 8'h2F);
                6: lk_cmd(a, int'($urandom_range(0, 255)));
                7: wr(a, int'($urandom_range(0, 255)));
                default: look(blk_base(int'($urandom_range(0, NB - 1)),
                                       int'($urandom_range(0, 1))) + 2);
            endcase
            if (i == 400) begin
                @(negedge clk); rst_n = 1'b0;
                @(negedge clk); rst_n = 1'b1;
            end
        end
        look(32'h00002);
        finish_run();
    end
endmodule